// File: doc/BRIEF.md
# Three-Decade Event Counter with Held, Scanned Digit Output

This block counts falling edges of an external pulse input with three cascaded decimal decades (units, tens, hundreds). The pulse input is first brought into the system-clock domain, and a falling edge seen there advances the units decade. Carries move synchronously into the higher decades. A gate input stops pulses from reaching the decades but keeps the count they hold. An overflow output goes high when the count wraps from 999 to 000, so a second block can be chained on it.

Behind each decade is a four-bit hold register. While the hold input is low, this register tracks its decade. When the hold input is high, it freezes. The held digits leave the block one at a time on a shared four-bit bus. An active-low, one-hot select vector shows which digit is on the bus. A scan tick, given as a clock enable, steps the select vector through the digits.

A master reset clears the decades, the overflow output and the scanner. It leaves a frozen hold register alone. While the reset is high, every select line is inactive.

Top module: `bcd3_scan_counter`

## Requirements
- R1: Each decade holds a BCD value 0..9 (4 bits, 9 wraps to 0 with a carry into the next decade). The count goes up by exactly one for each falling edge of `countIn`. That input is synchronised, so each high and low phase must last at least two clocks. The counters update three clock edges after `countIn` falls.
- R2: While `gateHold` is high, falling edges of `countIn` change no decade, and the present count is kept.
- R3: While `latchHold` is low, each hold register takes its decade's value every clock. While `latchHold` is high, the hold registers keep the value they had when it rose.
- R4: While `masterRst` is high, all decades and `overflow` are cleared on each clock. If `latchHold` stays high through the reset, the held digits are unchanged. Once `latchHold` is low again, the bus shows the cleared count.
- R5: While `masterRst` is high, `digitSelN` is 3'b111, the scanner is held on the units digit, and `scanTick` is ignored. After `sysRstN` low, `digitSelN` is 3'b111, `bcdOut` is 0 and `overflow` is 0.
- R6: With `masterRst` low, each clock with `scanTick` high moves the scanner one step in the order units, tens, hundreds, units. `digitSelN` bit i is low only for the selected digit (bit 0 units, bit 2 hundreds). The first selection after reset is 3'b110.
- R7: `bcdOut` carries the held BCD value of the digit whose select bit is low.
- R8: `overflow` rises on the count step that wraps 999 to 000 and falls on the next count step, giving one falling edge per 1000 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| masterRst | input | 1 | Synchronous active-high counter and scanner reset |
| countIn | input | 1 | Asynchronous pulse input, counted on its falling edge |
| gateHold | input | 1 | High blocks counting and keeps the count |
| latchHold | input | 1 | High freezes the digit hold registers |
| scanTick | input | 1 | One-clock enable that steps the digit scanner |
| bcdOut | output | 4 | BCD value of the selected digit, active high |
| digitSelN | output | 3 | Active-low one-hot digit select, bit 0 = units |
| overflow | output | 1 | High from the 999-to-000 wrap until the next count |

## Verification
The assertions take three things for granted. `masterRst`, `gateHold`, `latchHold` and `scanTick` change only in step with `clk`. `countIn` stays in each state long enough to pass the synchroniser. `sysRstN` is applied before anything else. The bench changes every input on the falling clock edge. It holds each phase of `countIn` for two full clocks and waits out the synchroniser and hold-register latency before it reads a digit. It also waits for the scanner to reach the wanted select pattern before it samples the bus.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;
  localparam int BCD_W = 4;
  localparam logic [BCD_W-1:0] BCD_TOP = 4'd9;

  typedef struct packed {
    logic advance;
    logic clearCnt;
    logic holdLatch;
  } strobe_t;
endpackage

// File: rtl/bcd3_control.sv
module bcd3_control import bcd3_pkg::*; #(
  parameter int DIGITS = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             masterRst,
  input  logic             countIn,
  input  logic             gateHold,
  input  logic             latchHold,
  input  logic             scanTick,
  output strobe_t          strobes,
  output logic [IDX_W-1:0] scanIdx,
  output logic [DIGITS-1:0] digitSelN
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevLvl;
  logic fallSeen;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], countIn};
      prevLvl <= syncQ[SYNC_STAGES-1];
    end
  end

  assign fallSeen = prevLvl & ~syncQ[SYNC_STAGES-1];

  always_comb begin
    strobes.advance   = fallSeen & ~gateHold & ~masterRst;
    strobes.clearCnt  = masterRst;
    strobes.holdLatch = latchHold;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)
      scanIdx <= '0;
    else if (masterRst)
      scanIdx <= '0;
    else if (scanTick)
      scanIdx <= (scanIdx == IDX_W'(DIGITS - 1)) ? '0 : scanIdx + 1'b1;
  end

  always_comb begin
    digitSelN = '1;
    if (sysRstN && !masterRst) begin
      for (int i = 0; i < DIGITS; i++)
        if (scanIdx == IDX_W'(i)) digitSelN[i] = 1'b0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!sysRstN)
    !masterRst |-> $countones(~digitSelN) == 1); // R6
  AST_RST_BLANK: assert property (@(posedge clk) disable iff (!sysRstN)
    masterRst |-> &digitSelN); // R5
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!sysRstN)
    (!masterRst && scanTick && !digitSelN[0]) |=> (masterRst || !digitSelN[1])); // R6
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!sysRstN)
    $past(gateHold) |-> !$past(strobes.advance)); // R2
endmodule

// File: rtl/bcd3_datapath.sv
module bcd3_datapath import bcd3_pkg::*; #(
  parameter int DIGITS = 3,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  strobe_t          strobes,
  input  logic [IDX_W-1:0] scanIdx,
  output logic [BCD_W-1:0] bcdOut,
  output logic             overflow
);
  logic [BCD_W-1:0] cnt    [DIGITS];
  logic [BCD_W-1:0] heldQ  [DIGITS];
  logic [DIGITS:0]  carry;
  logic [DIGITS*BCD_W-1:0] heldFlat;
  logic [DIGITS*BCD_W-1:0] cntFlat;

  assign carry[0] = strobes.advance;

  for (genvar i = 0; i < DIGITS; i++) begin : g_decade
    assign carry[i+1] = carry[i] & (cnt[i] == BCD_TOP);
    assign heldFlat[i*BCD_W +: BCD_W] = heldQ[i];
    assign cntFlat[i*BCD_W +: BCD_W]  = cnt[i];

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN)
        cnt[i] <= '0;
      else if (strobes.clearCnt)
        cnt[i] <= '0;
      else if (carry[i])
        cnt[i] <= (cnt[i] == BCD_TOP) ? '0 : cnt[i] + 1'b1;
    end

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN)
        heldQ[i] <= '0;
      else if (!strobes.holdLatch)
        heldQ[i] <= cnt[i];
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!sysRstN)
      cnt[i] <= BCD_TOP); // R1
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)
      overflow <= 1'b0;
    else if (strobes.clearCnt)
      overflow <= 1'b0;
    else if (carry[DIGITS])
      overflow <= 1'b1;
    else if (strobes.advance)
      overflow <= 1'b0;
  end

  always_comb begin
    bcdOut = '0;
    for (int i = 0; i < DIGITS; i++)
      if (scanIdx == IDX_W'(i)) bcdOut = heldQ[i];
  end

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(overflow) |-> cntFlat == '0); // R8
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.holdLatch |=> $stable(heldFlat)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.clearCnt |=> (cntFlat == '0 && !overflow)); // R4
endmodule

// File: rtl/bcd3_scan_counter.sv
module bcd3_scan_counter import bcd3_pkg::*; #(
  parameter int DIGITS = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              masterRst,
  input  logic              countIn,
  input  logic              gateHold,
  input  logic              latchHold,
  input  logic              scanTick,
  output logic [BCD_W-1:0]  bcdOut,
  output logic [DIGITS-1:0] digitSelN,
  output logic              overflow
);
  strobe_t          strobes;
  logic [IDX_W-1:0] scanIdx;

  bcd3_control #(.DIGITS(DIGITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .masterRst(masterRst), .countIn(countIn),
    .gateHold(gateHold), .latchHold(latchHold), .scanTick(scanTick),
    .strobes(strobes), .scanIdx(scanIdx), .digitSelN(digitSelN)
  );

  bcd3_datapath #(.DIGITS(DIGITS)) u_data (
    .clk(clk), .sysRstN(sysRstN), .strobes(strobes), .scanIdx(scanIdx),
    .bcdOut(bcdOut), .overflow(overflow)
  );
endmodule

// File: tb/sim_bcd3_scan_counter.sv
module sim_bcd3_scan_counter;
  logic clk = 1'b0;
  logic sysRstN = 1'b0, masterRst = 1'b0, countIn = 1'b0;
  logic gateHold = 1'b0, latchHold = 1'b0, scanTick = 1'b0;
  logic [3:0] bcdOut;
  logic [2:0] digitSelN;
  logic overflow;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd3_scan_counter u0 (.clk(clk), .sysRstN(sysRstN), .masterRst(masterRst),
    .countIn(countIn), .gateHold(gateHold), .latchHold(latchHold),
    .scanTick(scanTick), .bcdOut(bcdOut), .digitSelN(digitSelN),
    .overflow(overflow));

  localparam int NV = 5;
  localparam int V_PULSES [NV] = '{5, 7, 3, 88, 899};
  localparam int V_GATE   [NV] = '{0, 0, 1, 0, 0};
  localparam int V_EXP    [NV] = '{5, 12, 12, 100, 999};

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) countIn = 1'b1;
      repeat (2) @(negedge clk);
      countIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) scanTick = 1'b1;
    @(negedge clk) scanTick = 1'b0;
  endtask

  task automatic readCount(output int val);
    int dig [3];
    for (int d = 0; d < 3; d++) begin
      for (int t = 0; t < 4 && digitSelN != ~(3'b001 << d); t++) tick();
      @(negedge clk);
      dig[d] = int'(bcdOut);
    end
    val = dig[0] + 10 * dig[1] + 100 * dig[2];
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 sel in reset", int'(digitSelN), 7);
    check("R5 bcd in reset", int'(bcdOut), 0);
    check("R5 ovf in reset", int'(overflow), 0);
    sysRstN = 1'b1;
    @(negedge clk);
    check("R6 first select", int'(digitSelN), 6);

    // R1 R2 R7 vector table
    for (int i = 0; i < NV; i++) begin
      gateHold = V_GATE[i][0];
      pulse(V_PULSES[i]);
      gateHold = 1'b0;
      @(negedge clk);
      readCount(v);
      check(V_GATE[i] != 0 ? "R2 gate" : "R1 R7 count", v, V_EXP[i]);
    end

    // R8 wrap
    check("R8 ovf before wrap", int'(overflow), 0);
    pulse(1);
    check("R8 ovf at wrap", int'(overflow), 1);
    readCount(v);
    check("R1 wrap to zero", v, 0);
    pulse(1);
    check("R8 ovf falls", int'(overflow), 0);

    // R3 hold
    latchHold = 1'b1;
    repeat (2) @(negedge clk);
    pulse(3);
    readCount(v);
    check("R3 held value", v, 1);

    // R4 reset with hold
    masterRst = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 blank in mreset", int'(digitSelN), 7);
    tick();
    check("R5 tick ignored", int'(digitSelN), 7);
    masterRst = 1'b0;
    @(negedge clk);
    check("R5 units after mreset", int'(digitSelN), 6);
    readCount(v);
    check("R4 hold survives reset", v, 1);
    latchHold = 1'b0;
    repeat (2) @(negedge clk);
    readCount(v);
    check("R4 cleared count", v, 0);

    // R6 scan order
    while (digitSelN != 3'b110) tick();
    tick(); check("R6 tens", int'(digitSelN), 5);
    tick(); check("R6 hundreds", int'(digitSelN), 3);
    tick(); check("R6 back to units", int'(digitSelN), 6);

    // R7 distinct digits
    pulse(321);
    readCount(v);
    check("R7 mux 321", v, 321);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule